// File: doc/BRIEF.md
# Shared GPIO and Serial-Clock Pin Controller

This block governs one bidirectional port pin that serves two masters: software, through three one-bit registers (latched output level, direction and pulldown inhibit), and a synchronous serial unit that needs the pin as its clock line. When the serial unit is switched off, the registers decide whether the pin drives, floats or is pulled low. When it is switched on, the serial unit takes the pin, and its master-select control sets whether the pin sends the internal serial clock out or brings an external clock in.

The software registers stay live during serial operation. They can be written and read back without disturbing the pin, and the values they hold take over the pin again in the same cycle that serial enable drops. Reads of the data register return the live pin level when the pin is an input and the latched bit when it is an output. The serial shifter, the analog pad and the processor are outside this block; the pad is seen as an output value, an output enable, a pulldown enable and a received level.

Top module: `sck_gpio_pin`

## Requirements
- R1: After a synchronous reset the data, direction and inhibit bits are all 0, so pad_oe is 0 and pad_pd_en is 1 while serial is disabled.
- R2: With ser_en=1 and ser_master=1, pad_oe is 1, pad_out follows ser_clk_out in the same cycle, and ser_clk_in returns ser_clk_out.
- R3: With ser_en=1 and ser_master=0, pad_oe is 0 and ser_clk_in follows pad_in in the same cycle.
- R4: pad_pd_en is 0 in every cycle where ser_en is 1.
- R5: Bus writes to the data, direction or inhibit address while ser_en is 1 leave pad_oe, pad_out and pad_pd_en unchanged.
- R6: The direction and data bits written while ser_en is 1 are stored and can be read back while serial stays enabled.
- R7: With ser_en=0, pad_oe equals the direction bit and pad_out equals the data bit, and this holds from the first cycle after ser_en falls.
- R8: With ser_en=0, pad_pd_en is 1 only when the direction bit and the inhibit bit are both 0; a driven pin never has its pulldown on.
- R9: A read of the data address returns, in bit 7, pad_in when the direction bit is 0 and the latched data bit when it is 1.
- R10: The data bit is at address 0x01, the direction bit at 0x05 and the write-only inhibit bit at 0x11, each in bit 7 of the bus word; reads of 0x11 or of any unmapped address, all other bit positions, and bus_rdata when bus_rd is 0 are 0.
- R11: With ser_en=0, ser_clk_in is 0.
- R12: A register write applied in one cycle is visible at the pad and on read-back from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data; bit 7 carries the register value |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, combinational from address and pin |
| ser_en | input | 1 | Serial unit owns the pin |
| ser_master | input | 1 | Serial unit sources the clock |
| ser_clk_out | input | 1 | Internal serial clock from the serial unit |
| ser_clk_in | output | 1 | Clock returned to the serial unit |
| pad_in | input | 1 | Level received from the pad |
| pad_out | output | 1 | Level driven onto the pad |
| pad_oe | output | 1 | Pad output buffer enable |
| pad_pd_en | output | 1 | Pad pulldown enable |

## Verification
The only state in the block is three register bits, so a wrong stored value shows at the pad one cycle after the write that set it if serial is disabled, and on read-back of the data or direction address at once. While serial owns the pin a corrupted bit is masked at the pad and surfaces only through read-back or in the first cycle after ser_en falls, which is why the bench writes values under serial ownership and then drops ownership. The reference model is compared against every output on every clock, so an ownership or pulldown error is caught in the cycle it appears.

// File: rtl/sck_gpio_pin_pkg.sv
package sck_gpio_pin_pkg;

    // Who currently decides the pin buffer
    typedef enum logic [1:0] {
        OWN_PORT       = 2'd0,
        OWN_SER_SOURCE = 2'd1,
        OWN_SER_SINK   = 2'd2
    } pin_owner_e;

    // Stored software state of the pin
    typedef struct packed {
        logic lvl;      // latched output level
        logic drive;    // 1 = output
        logic pd_inh;   // 1 = pulldown inhibited
    } port_bits_t;

    // Everything sent toward the pad and the serial unit
    typedef struct packed {
        logic out;
        logic oe;
        logic pd_en;
        logic clk_back;
    } pad_ctl_t;

    localparam int NUM_BITS = 3;

    function automatic pin_owner_e pick_owner(input logic en, input logic src);
        if (!en)      return OWN_PORT;
        else if (src) return OWN_SER_SOURCE;
        else          return OWN_SER_SINK;
    endfunction

endpackage

// File: rtl/sck_gpio_pin_regs.sv
module sck_gpio_pin_regs
    import sck_gpio_pin_pkg::*;
#(
    parameter int                ADDR_W  = 8,
    parameter int                DATA_W  = 8,
    parameter int                PIN_BIT = 7,
    parameter logic [ADDR_W-1:0] A_LVL   = 8'h01,
    parameter logic [ADDR_W-1:0] A_DRV   = 8'h05,
    parameter logic [ADDR_W-1:0] A_INH   = 8'h11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    output port_bits_t        bits_o
);

    localparam logic [ADDR_W-1:0] ADDR_TAB [NUM_BITS] = '{A_LVL, A_DRV, A_INH};

    logic [NUM_BITS-1:0] bit_q;

    for (genvar i = 0; i < NUM_BITS; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                bit_q[i] <= 1'b0;
            else if (bus_wr && bus_addr == ADDR_TAB[i])
                bit_q[i] <= bus_wdata[PIN_BIT];
        end
    end

    always_comb begin
        bits_o.lvl    = bit_q[0];
        bits_o.drive  = bit_q[1];
        bits_o.pd_inh = bit_q[2];
    end

    // R12: a write lands in the addressed bit on the next edge
    a_r12_dir_write: assert property (@(posedge clk) disable iff (rst)
        $past(bus_wr && bus_addr == A_DRV) |-> bits_o.drive == $past(bus_wdata[PIN_BIT]));

    a_r12_lvl_write: assert property (@(posedge clk) disable iff (rst)
        $past(bus_wr && bus_addr == A_LVL) |-> bits_o.lvl == $past(bus_wdata[PIN_BIT]));

    // R1: state is cleared after reset
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (bits_o == '0));

endmodule

// File: rtl/sck_gpio_pin_route.sv
module sck_gpio_pin_route
    import sck_gpio_pin_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ser_en,
    input  logic       ser_master,
    input  logic       ser_clk_out,
    input  logic       pad_in,
    input  port_bits_t bits_i,
    output pad_ctl_t   ctl_o
);

    pin_owner_e owner;

    always_comb begin
        owner = pick_owner(ser_en, ser_master);
        ctl_o = '0;
        unique case (owner)
            OWN_SER_SOURCE: begin
                ctl_o.oe       = 1'b1;
                ctl_o.out      = ser_clk_out;
                ctl_o.clk_back = ser_clk_out;
            end
            OWN_SER_SINK: begin
                ctl_o.clk_back = pad_in;
            end
            default: begin
                ctl_o.oe    = bits_i.drive;
                ctl_o.out   = bits_i.lvl;
                ctl_o.pd_en = ~bits_i.drive & ~bits_i.pd_inh;
            end
        endcase
    end

    // R2: clock source drives the pin
    a_r2_source_drive: assert property (@(posedge clk) disable iff (rst)
        (ser_en && ser_master) |-> (ctl_o.oe && ctl_o.out == ser_clk_out));

    // R3: clock sink releases the pin and listens
    a_r3_sink_listen: assert property (@(posedge clk) disable iff (rst)
        (ser_en && !ser_master) |-> (!ctl_o.oe && ctl_o.clk_back == pad_in));

    // R4: no pulldown under serial ownership
    a_r4_ser_no_pull: assert property (@(posedge clk) disable iff (rst)
        ser_en |-> !ctl_o.pd_en);

    // R8: never pull down a driven pin
    a_r8_driven_no_pull: assert property (@(posedge clk) disable iff (rst)
        ctl_o.oe |-> !ctl_o.pd_en);

    // R11: no clock returned while the port owns the pin
    a_r11_port_no_clk: assert property (@(posedge clk) disable iff (rst)
        !ser_en |-> !ctl_o.clk_back);

    // R5: ownership held across cycles keeps the buffer state fixed
    a_r5_held_oe: assert property (@(posedge clk) disable iff (rst)
        (ser_en && $past(ser_en) && $stable(ser_master)) |-> ($stable(ctl_o.oe) && !ctl_o.pd_en));

endmodule

// File: rtl/sck_gpio_pin_rdmux.sv
module sck_gpio_pin_rdmux
    import sck_gpio_pin_pkg::*;
#(
    parameter int                ADDR_W  = 8,
    parameter int                DATA_W  = 8,
    parameter int                PIN_BIT = 7,
    parameter logic [ADDR_W-1:0] A_LVL   = 8'h01,
    parameter logic [ADDR_W-1:0] A_DRV   = 8'h05
) (
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              pad_in,
    input  port_bits_t        bits_i,
    output logic [DATA_W-1:0] rdata_o
);

    always_comb begin
        rdata_o = '0;
        if (bus_rd) begin
            if (bus_addr == A_LVL)
                rdata_o[PIN_BIT] = bits_i.drive ? bits_i.lvl : pad_in;
            else if (bus_addr == A_DRV)
                rdata_o[PIN_BIT] = bits_i.drive;
        end
    end

endmodule

// File: rtl/sck_gpio_pin.sv
module sck_gpio_pin
    import sck_gpio_pin_pkg::*;
#(
    parameter int                ADDR_W  = 8,
    parameter int                DATA_W  = 8,
    parameter int                PIN_BIT = 7,
    parameter logic [ADDR_W-1:0] A_LVL   = 8'h01,
    parameter logic [ADDR_W-1:0] A_DRV   = 8'h05,
    parameter logic [ADDR_W-1:0] A_INH   = 8'h11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ser_en,
    input  logic              ser_master,
    input  logic              ser_clk_out,
    output logic              ser_clk_in,
    input  logic              pad_in,
    output logic              pad_out,
    output logic              pad_oe,
    output logic              pad_pd_en
);

    port_bits_t bits;
    pad_ctl_t   ctl;

    sck_gpio_pin_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PIN_BIT(PIN_BIT),
        .A_LVL(A_LVL), .A_DRV(A_DRV), .A_INH(A_INH)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_wr   (bus_wr),
        .bits_o   (bits)
    );

    sck_gpio_pin_route u_route (
        .clk        (clk),
        .rst        (rst),
        .ser_en     (ser_en),
        .ser_master (ser_master),
        .ser_clk_out(ser_clk_out),
        .pad_in     (pad_in),
        .bits_i     (bits),
        .ctl_o      (ctl)
    );

    sck_gpio_pin_rdmux #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PIN_BIT(PIN_BIT),
        .A_LVL(A_LVL), .A_DRV(A_DRV)
    ) u_rdmux (
        .bus_rd  (bus_rd),
        .bus_addr(bus_addr),
        .pad_in  (pad_in),
        .bits_i  (bits),
        .rdata_o (bus_rdata)
    );

    assign pad_out    = ctl.out;
    assign pad_oe     = ctl.oe;
    assign pad_pd_en  = ctl.pd_en;
    assign ser_clk_in = ctl.clk_back;

    // R9: an input pin reads back its live level
    a_r9_live_read: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == A_LVL && !ser_en && !pad_oe) |-> bus_rdata[PIN_BIT] == pad_in);

    // R7: port owner drives what the read-back reports
    a_r7_port_drive: assert property (@(posedge clk) disable iff (rst)
        (!ser_en && pad_oe && bus_rd && bus_addr == A_LVL) |-> bus_rdata[PIN_BIT] == pad_out);

    // R10: the write-only address reads as zero
    a_r10_inh_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == A_INH) |-> bus_rdata == '0);

endmodule

// File: tb/sim_sck_gpio_pin.sv
module sim_sck_gpio_pin;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic       ser_en = 1'b0;
    logic       ser_master = 1'b0;
    logic       ser_clk_out = 1'b0;
    logic       ser_clk_in;
    logic       pad_in = 1'b0;
    logic       pad_out;
    logic       pad_oe;
    logic       pad_pd_en;

    int total = 0;
    int bad = 0;
    bit done = 0;
    bit toggle_sclk = 0;

    // reference state
    int m_lvl = 0, m_drv = 0, m_inh = 0;

    always #10 clk = ~clk;

    sck_gpio_pin u0 (
        .clk(clk), .rst(rst),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .ser_en(ser_en), .ser_master(ser_master),
        .ser_clk_out(ser_clk_out), .ser_clk_in(ser_clk_in),
        .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .pad_pd_en(pad_pd_en)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // reference register update
    always @(posedge clk) begin
        if (rst) begin
            m_lvl = 0; m_drv = 0; m_inh = 0;
        end else if (bus_wr) begin
            if (bus_addr == 8'h01) m_lvl = int'(bus_wdata[7]);
            if (bus_addr == 8'h05) m_drv = int'(bus_wdata[7]);
            if (bus_addr == 8'h11) m_inh = int'(bus_wdata[7]);
        end
    end

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (!rst) begin
            int e_oe, e_out, e_pd, e_cin, e_rd;
            string tg;
            if (ser_en && ser_master) begin
                e_oe = 1; e_out = int'(ser_clk_out); e_pd = 0; e_cin = int'(ser_clk_out); tg = "R2";
            end else if (ser_en) begin
                e_oe = 0; e_out = 0; e_pd = 0; e_cin = int'(pad_in); tg = "R3";
            end else begin
                e_oe = m_drv; e_out = m_lvl; e_pd = (m_drv == 0 && m_inh == 0) ? 1 : 0;
                e_cin = 0; tg = "R7";
            end
            e_rd = 0;
            if (bus_rd && bus_addr == 8'h01) e_rd = (m_drv != 0 ? m_lvl : int'(pad_in)) * 128;
            else if (bus_rd && bus_addr == 8'h05) e_rd = m_drv * 128;
            check({tg, " pad_oe"}, int'(pad_oe), e_oe);
            check({tg, " pad_out"}, int'(pad_out), e_out);
            check(ser_en ? "R4 pad_pd_en" : "R8 pad_pd_en", int'(pad_pd_en), e_pd);
            check(ser_en ? {tg, " ser_clk_in"} : "R11 ser_clk_in", int'(ser_clk_in), e_cin);
            check("R10 bus_rdata", int'(bus_rdata), e_rd);
        end
    end

    always @(posedge clk) if (toggle_sclk) ser_clk_out <= ~ser_clk_out;

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        step();
        bus_wr = 1'b0; bus_wdata = 8'h00;
    endtask

    task automatic rd_check(input string tag, input logic [7:0] a, input int exp);
        bus_addr = a; bus_rd = 1'b1;
        #5;
        check(tag, int'(bus_rdata), exp);
        step();
        bus_rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        // R1 reset state
        check("R1 pad_oe after reset", int'(pad_oe), 0);
        check("R1 pad_pd_en after reset", int'(pad_pd_en), 1);
        rd_check("R1 dir reads 0", 8'h05, 0);

        // R10 idle read bus and write-only / unmapped addresses
        wr(8'h11, 8'h7F);
        bus_addr = 8'h05; #2;
        check("R10 rdata zero without bus_rd", int'(bus_rdata), 0);
        rd_check("R10 inhibit addr reads 0", 8'h11, 0);
        rd_check("R10 unmapped reads 0", 8'h33, 0);

        // R9 input read returns live pin
        pad_in = 1'b1;
        rd_check("R9 live level high", 8'h01, 128);
        pad_in = 1'b0;
        rd_check("R9 live level low", 8'h01, 0);

        // R7 / R12 port output
        wr(8'h01, 8'hFF);
        check("R12 data write visible next cycle, pad_oe still 0", int'(pad_oe), 0);
        wr(8'h05, 8'h80);
        check("R7 pad_oe follows dir", int'(pad_oe), 1);
        check("R7 pad_out follows data", int'(pad_out), 1);
        check("R8 no pulldown when driven", int'(pad_pd_en), 0);
        rd_check("R9 latched read despite pad_in=0", 8'h01, 128);
        rd_check("R10 dir reads only bit 7", 8'h05, 128);

        // R8 inhibit
        wr(8'h05, 8'h00);
        check("R8 pulldown on as input", int'(pad_pd_en), 1);
        wr(8'h11, 8'h80);
        check("R8 pulldown inhibited", int'(pad_pd_en), 0);
        wr(8'h11, 8'h00);

        // R2 source mode with toggling clock
        ser_en = 1'b1; ser_master = 1'b1; toggle_sclk = 1;
        repeat (6) step();
        check("R2 pad_oe in source mode", int'(pad_oe), 1);
        check("R4 no pulldown in source mode", int'(pad_pd_en), 0);

        // R5 / R6 writes under serial ownership
        wr(8'h05, 8'h00);
        wr(8'h01, 8'h00);
        wr(8'h11, 8'h80);
        check("R5 pad_oe unchanged by writes", int'(pad_oe), 1);
        rd_check("R6 dir read back under serial", 8'h05, 0);

        // R3 sink mode
        ser_master = 1'b0; toggle_sclk = 0;
        for (int i = 0; i < 6; i++) begin
            pad_in = i[0];
            step();
        end
        check("R3 pad_oe released in sink mode", int'(pad_oe), 0);
        wr(8'h05, 8'h80);
        wr(8'h01, 8'h80);
        check("R5 sink stays released after dir write", int'(pad_oe), 0);
        rd_check("R6 data read back under serial", 8'h01, 128);

        // R7 resume on serial disable
        ser_en = 1'b0; #2;
        check("R7 stored dir resumes at once", int'(pad_oe), 1);
        check("R7 stored data resumes at once", int'(pad_out), 1);
        check("R11 no clock back when port owns", int'(ser_clk_in), 0);
        wr(8'h05, 8'h00);
        check("R8 inhibit written under serial applies", int'(pad_pd_en), 0);

        // R1 reset mid-run
        rst = 1'b1; step(); step(); rst = 1'b0; step();
        check("R1 pulldown back after reset", int'(pad_pd_en), 1);
        step();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule